// File: doc/BRIEF.md
# Serial FIFO Occupancy Flags and Interrupt Combiner

This block tracks how full the two 8-byte queues of a serial peripheral are. The transmit queue is filled by the bus and drained by the shifter. The receive queue is filled by the shifter and drained by the bus. Only the occupancy counters and the flags are built here. Data storage, the shifter and clock generation sit outside the block. The block reports its flags in a 32-bit status word and drives one registered interrupt line. Each interrupt source has its own enable bit.

The transmit half-level flag is sticky. Once the transmit level reaches the middle mark, the flag stays set until the bus writes another byte. The receive side has two overrun indications. A warning marks the push that fills the queue, and an error marks a push that arrives while the queue is already full. One enable covers both indications. Software clears either overrun indication by writing 0 to its bit.

Top module: `fifo_flag_ctl`

## Requirements
- R1: After reset the status word reads 0x0000_0122 in FIFO mode (transmit empty in bit 8, receive empty in bit 5, transmit not-full in bit 1), and irq is 0.
- R2: The transmit level counts accepted bus pushes and shifter pops. A push is refused when the level is 8. Bit 10 reads 1 at level 8, bit 8 at level 0, bit 1 below level 8, and bit 0 at level 7 or more.
- R3: Bit 9 (transmit half-level) sets in the cycle the transmit level changes to 4. It stays set when pops lower the level. It clears on an accepted bus push, unless that same push sets it.
- R4: For the receive level, bit 5 reads 1 at level 0, bit 6 at level 4 or more, bit 2 at level 7 or more, and bit 7 at level 8.
- R5: A shifter push while the receive level is 8 sets bit 4 (overrun error), and the byte is dropped: eight pops then empty the queue.
- R6: A receive push that brings the level from 7 to 8 sets bit 3 (overrun warning).
- R7: A write with bit 4 or bit 3 at 0 clears that flag. Writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R8: Bits 31 to 11 always read 0.
- R9: With fifoMode at 0, bits 10 to 5 and 2 to 0 read 0, and their interrupt sources are off. The overrun bits 4 and 3 still operate.
- R10: irq equals, one clock later, the OR of the enabled sources. The ctrlEn bits are 0 overrun, 1 transmit done (txDoneIn), 2 receive not empty, 3 receive half, 4 receive full, 5 transmit empty and 6 transmit half.
- R11: Enable bit 0 raises irq on the overrun warning alone and on the overrun error alone.
- R12: A pop on an empty queue is ignored.
- R13: An accepted push and pop in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| fifoMode | input | 1 | Level flags valid when 1 |
| txPush | input | 1 | Bus writes a transmit byte |
| txPop | input | 1 | Shifter takes a transmit byte |
| rxPush | input | 1 | Shifter delivers a receive byte |
| rxPop | input | 1 | Bus reads a receive byte |
| txDoneIn | input | 1 | Transmit-complete status from the shifter |
| ctrlEn | input | 7 | Per-source interrupt enables |
| swWrEn | input | 1 | Software write to the status word |
| swWrData | input | 32 | Write data (bits 4 and 3 used) |
| statusWord | output | 32 | Flag word |
| irq | output | 1 | Registered interrupt request |

## Verification
A vector table walks the transmit queue up to full, into a refused push, through combined push and pop cycles, and down to empty. These steps tell the level-derived flags apart from the sticky half-level flag, which clears only on a write. The receive queue is then driven to the 7-to-8 step and past it. This separates the warning from the error and shows that the extra byte is dropped. Directed steps then write ones and zeros to the overrun bits and switch FIFO mode off. The irq checks sample the output one cycle before and one cycle after a source changes, which exposes a missing register or a wrongly routed enable.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam int STAT_W  = 32;
  localparam int NUM_SRC = 7;
  localparam int FLAG_W  = 11;

  // status bit positions (software decodes these)
  localparam int B_TXFULL  = 10;
  localparam int B_TXHALF  = 9;
  localparam int B_TXEMPTY = 8;
  localparam int B_RXFULL  = 7;
  localparam int B_RXHALF  = 6;
  localparam int B_RXEMPTY = 5;
  localparam int B_RXOVR   = 4;
  localparam int B_RXWARN  = 3;
  localparam int B_RXNEAR  = 2;
  localparam int B_TXNFULL = 1;
  localparam int B_TXNEAR  = 0;

  // interrupt enable positions
  localparam int E_OVR    = 0;
  localparam int E_TXDONE = 1;
  localparam int E_RXNE   = 2;
  localparam int E_RXHALF = 3;
  localparam int E_RXFULL = 4;
  localparam int E_TXEMPT = 5;
  localparam int E_TXHALF = 6;

  typedef struct packed {
    logic txPushOk;
    logic txPopOk;
    logic rxPushOk;
    logic rxPopOk;
    logic ovrSet;
    logic warnSet;
    logic txHalfSet;
    logic txHalfClr;
    logic ovrClr;
    logic warnClr;
  } ffc_strb_t;
endpackage

// File: rtl/ffc_level_ctr.sv
module ffc_level_ctr #(
  parameter int DEPTH = 8,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            incOk,
  input  logic            decOk,
  output logic [LVLW-1:0] level
);
  logic [LVLW-1:0] incV;
  logic [LVLW-1:0] decV;

  assign incV = {{(LVLW-1){1'b0}}, incOk};
  assign decV = {{(LVLW-1){1'b0}}, decOk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) level <= '0;
    else       level <= level + incV - decV;
  end
endmodule

// File: rtl/ffc_ctrl.sv
module ffc_ctrl
  import ffc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic [LVLW-1:0] txLevel,
  input  logic [LVLW-1:0] rxLevel,
  input  logic            txPush,
  input  logic            txPop,
  input  logic            rxPush,
  input  logic            rxPop,
  input  logic            swWrEn,
  input  logic            swOvrBit,
  input  logic            swWarnBit,
  output ffc_strb_t       strb
);
  localparam logic [LVLW-1:0] FULL_L = LVLW'(DEPTH);
  localparam logic [LVLW-1:0] HALF_L = LVLW'(DEPTH / 2);
  localparam logic [LVLW-1:0] NEAR_L = LVLW'(DEPTH - 1);

  logic            txPushOk, txPopOk, rxPushOk, rxPopOk;
  logic [LVLW-1:0] txNext;

  always_comb begin
    txPushOk = txPush && (txLevel != FULL_L);
    txPopOk  = txPop  && (txLevel != '0);
    rxPushOk = rxPush && (rxLevel != FULL_L);
    rxPopOk  = rxPop  && (rxLevel != '0);
    txNext   = txLevel + {{(LVLW-1){1'b0}}, txPushOk} - {{(LVLW-1){1'b0}}, txPopOk};

    strb.txPushOk  = txPushOk;
    strb.txPopOk   = txPopOk;
    strb.rxPushOk  = rxPushOk;
    strb.rxPopOk   = rxPopOk;
    strb.ovrSet    = rxPush && (rxLevel == FULL_L);
    strb.warnSet   = rxPushOk && !rxPopOk && (rxLevel == NEAR_L);
    strb.txHalfSet = (txNext == HALF_L) && (txNext != txLevel);
    strb.txHalfClr = txPushOk;
    strb.ovrClr    = swWrEn && !swOvrBit;
    strb.warnClr   = swWrEn && !swWarnBit;
  end
endmodule

// File: rtl/ffc_datapath.sv
module ffc_datapath
  import ffc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ffc_strb_t          strb,
  input  logic               fifoMode,
  input  logic               txDoneIn,
  input  logic [NUM_SRC-1:0] ctrlEn,
  output logic [LVLW-1:0]    txLevel,
  output logic [LVLW-1:0]    rxLevel,
  output logic [STAT_W-1:0]  statusWord,
  output logic               irq
);
  localparam logic [LVLW-1:0] FULL_L = LVLW'(DEPTH);
  localparam logic [LVLW-1:0] HALF_L = LVLW'(DEPTH / 2);
  localparam logic [LVLW-1:0] NEAR_L = LVLW'(DEPTH - 1);

  logic [1:0]      incOk, decOk;
  logic [LVLW-1:0] lvl [2];

  assign incOk = {strb.rxPushOk, strb.txPushOk};
  assign decOk = {strb.rxPopOk,  strb.txPopOk};

  // index 0: transmit queue, index 1: receive queue
  for (genvar gi = 0; gi < 2; gi++) begin : g_ctr
    ffc_level_ctr #(.DEPTH(DEPTH), .LVLW(LVLW)) ctr_i (
      .clk   (clk),
      .rstN  (rstN),
      .incOk (incOk[gi]),
      .decOk (decOk[gi]),
      .level (lvl[gi])
    );
  end

  assign txLevel = lvl[0];
  assign rxLevel = lvl[1];

  logic txHalfQ, ovrQ, warnQ, irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHalfQ <= 1'b0;
      ovrQ    <= 1'b0;
      warnQ   <= 1'b0;
    end else begin
      if (strb.txHalfSet)      txHalfQ <= 1'b1;
      else if (strb.txHalfClr) txHalfQ <= 1'b0;
      if (strb.ovrSet)         ovrQ    <= 1'b1;
      else if (strb.ovrClr)    ovrQ    <= 1'b0;
      if (strb.warnSet)        warnQ   <= 1'b1;
      else if (strb.warnClr)   warnQ   <= 1'b0;
    end
  end

  logic [FLAG_W-1:0] rawFlags, levelMask, flags;

  always_comb begin
    rawFlags            = '0;
    rawFlags[B_TXFULL]  = (txLevel == FULL_L);
    rawFlags[B_TXHALF]  = txHalfQ;
    rawFlags[B_TXEMPTY] = (txLevel == '0);
    rawFlags[B_RXFULL]  = (rxLevel == FULL_L);
    rawFlags[B_RXHALF]  = (rxLevel >= HALF_L);
    rawFlags[B_RXEMPTY] = (rxLevel == '0);
    rawFlags[B_RXOVR]   = ovrQ;
    rawFlags[B_RXWARN]  = warnQ;
    rawFlags[B_RXNEAR]  = (rxLevel >= NEAR_L);
    rawFlags[B_TXNFULL] = (txLevel != FULL_L);
    rawFlags[B_TXNEAR]  = (txLevel >= NEAR_L);

    levelMask           = {FLAG_W{fifoMode}};
    levelMask[B_RXOVR]  = 1'b1;
    levelMask[B_RXWARN] = 1'b1;
    flags               = rawFlags & levelMask;
  end

  assign statusWord = {{(STAT_W-FLAG_W){1'b0}}, flags};

  logic [NUM_SRC-1:0] srcVec;

  always_comb begin
    srcVec           = '0;
    srcVec[E_OVR]    = flags[B_RXOVR] | flags[B_RXWARN];
    srcVec[E_TXDONE] = txDoneIn;
    srcVec[E_RXNE]   = fifoMode & ~rawFlags[B_RXEMPTY];
    srcVec[E_RXHALF] = flags[B_RXHALF];
    srcVec[E_RXFULL] = flags[B_RXFULL];
    srcVec[E_TXEMPT] = flags[B_TXEMPTY];
    srcVec[E_TXHALF] = flags[B_TXHALF];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(srcVec & ctrlEn);
  end

  assign irq = irqQ;
endmodule

// File: rtl/fifo_flag_ctl.sv
module fifo_flag_ctl
  import ffc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoMode,
  input  logic               txPush,
  input  logic               txPop,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic               txDoneIn,
  input  logic [NUM_SRC-1:0] ctrlEn,
  input  logic               swWrEn,
  input  logic [STAT_W-1:0]  swWrData,
  output logic [STAT_W-1:0]  statusWord,
  output logic               irq
);
  localparam int LVLW = $clog2(DEPTH + 1);

  ffc_strb_t       strb;
  logic [LVLW-1:0] txLevel, rxLevel;

  ffc_ctrl #(.DEPTH(DEPTH), .LVLW(LVLW)) ctrl_i (
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .txPush    (txPush),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .swWrEn    (swWrEn),
    .swOvrBit  (swWrData[B_RXOVR]),
    .swWarnBit (swWrData[B_RXWARN]),
    .strb      (strb)
  );

  ffc_datapath #(.DEPTH(DEPTH), .LVLW(LVLW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .fifoMode   (fifoMode),
    .txDoneIn   (txDoneIn),
    .ctrlEn     (ctrlEn),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .statusWord (statusWord),
    .irq        (irq)
  );
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        fifoMode,
  input logic        txPush,
  input logic        txPop,
  input logic        rxPush,
  input logic        txDoneIn,
  input logic [6:0]  ctrlEn,
  input logic        swWrEn,
  input logic [31:0] swWrData,
  input logic [31:0] statusWord,
  input logic        irq
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic [6:0] srcChk;
  assign srcChk = {statusWord[9], statusWord[8], statusWord[7], statusWord[6],
                   fifoMode & ~statusWord[5], txDoneIn,
                   statusWord[4] | statusWord[3]};

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:11] == 21'd0);

  // R12
  tx_empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && statusWord[8] && txPop && !txPush) |=> (!fifoMode || statusWord[8]));

  // R3
  tx_half_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && statusWord[9] && !txPush) |=> (!fifoMode || statusWord[9]));

  // R5
  rx_overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && statusWord[7] && rxPush) |=> statusWord[4]);

  // R7
  ovr_keep_on_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && swWrData[4] && statusWord[4]) |=> statusWord[4]);

  // R9
  mode_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |-> (statusWord[10:5] == 6'd0 && statusWord[2:0] == 3'd0));

  // R10
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    irq == $past(|(srcChk & ctrlEn)));
endmodule

bind fifo_flag_ctl ffc_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .fifoMode   (fifoMode),
  .txPush     (txPush),
  .txPop      (txPop),
  .rxPush     (rxPush),
  .txDoneIn   (txDoneIn),
  .ctrlEn     (ctrlEn),
  .swWrEn     (swWrEn),
  .swWrData   (swWrData),
  .statusWord (statusWord),
  .irq        (irq)
);

// File: tb/fifo_flag_ctl_tb_top.sv
`timescale 1ns/1ps
module fifo_flag_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoMode = 1'b1;
  logic        txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic        txDoneIn = 1'b0;
  logic [6:0]  ctrlEn = '0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic [31:0] statusWord;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_flag_ctl dut_i (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .txDoneIn(txDoneIn), .ctrlEn(ctrlEn), .swWrEn(swWrEn), .swWrData(swWrData),
    .statusWord(statusWord), .irq(irq)
  );

  // {repeat[3:0], ops {txPush,txPop,rxPush,rxPop}, expected status[10:0]}
  localparam logic [18:0] VEC [17] = '{
    {4'd3, 4'b1000, 11'h022},  // R2 three pushes
    {4'd1, 4'b1000, 11'h222},  // R3 reach 4
    {4'd2, 4'b0100, 11'h222},  // R3 sticky on pops
    {4'd1, 4'b1000, 11'h022},  // R3 cleared by push
    {4'd5, 4'b1000, 11'h421},  // R2 full
    {4'd1, 4'b1000, 11'h421},  // R2 push at full refused
    {4'd1, 4'b0100, 11'h023},  // R2 level 7
    {4'd2, 4'b1100, 11'h023},  // R13 push+pop
    {4'd3, 4'b0100, 11'h222},  // R3 reach 4 from above
    {4'd4, 4'b0100, 11'h322},  // R3 sticky to empty
    {4'd1, 4'b0100, 11'h322},  // R12 pop on empty
    {4'd4, 4'b0010, 11'h342},  // R4 rx half
    {4'd3, 4'b0010, 11'h346},  // R4 rx near full
    {4'd1, 4'b0010, 11'h3CE},  // R6 warning at 8
    {4'd1, 4'b0010, 11'h3DE},  // R5 overrun
    {4'd5, 4'b0001, 11'h31A},  // R4 rx drain
    {4'd3, 4'b0001, 11'h33A}   // R5 dropped byte: empty after 8 pops
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic swWrite(input logic [31:0] d);
    @(negedge clk);
    swWrEn = 1'b1; swWrData = d;
    @(negedge clk);
    swWrEn = 1'b0; swWrData = '0;
  endtask

  task automatic rxPushN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxPush = 1'b1;
    end
    @(negedge clk); rxPush = 1'b0;
  endtask

  initial begin
    doReset();
    chk("R1 reset status", statusWord, 32'h0000_0122);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    for (int v = 0; v < 17; v++) begin
      for (int r = 0; r < int'(VEC[v][18:15]); r++) begin
        @(negedge clk);
        {txPush, txPop, rxPush, rxPop} = VEC[v][14:11];
      end
      @(negedge clk);
      {txPush, txPop, rxPush, rxPop} = 4'b0000;
      chk($sformatf("R2-R6 table step %0d (R8 upper bits)", v), statusWord,
          {21'd0, VEC[v][10:0]});
    end

    swWrite(32'hFFFF_FFFF);
    chk("R7 write ones keeps", statusWord, 32'h0000_033A);
    swWrite(32'hFFFF_FFF7);
    chk("R7 clear warning", statusWord, 32'h0000_0332);
    swWrite(32'hFFFF_FFEF);
    chk("R7 clear overrun", statusWord, 32'h0000_0322);

    @(negedge clk); fifoMode = 1'b0; #1;
    chk("R9 mode off masks", statusWord, 32'h0);
    rxPushN(9);
    chk("R9 overrun flags live", statusWord, 32'h0000_0018);
    fifoMode = 1'b1;

    doReset();
    chk("R1 second reset", statusWord, 32'h0000_0122);

    @(negedge clk); ctrlEn = 7'b010_0000; #1;
    chk("R10 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 tx empty irq", {31'd0, irq}, 32'd1);

    ctrlEn = 7'b000_0100;
    @(negedge clk);
    chk("R10 rx empty no irq", {31'd0, irq}, 32'd0);
    rxPush = 1'b1;
    @(negedge clk); rxPush = 1'b0;
    chk("R10 one cycle lag", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 rx not empty irq", {31'd0, irq}, 32'd1);

    ctrlEn = 7'b000_0001;
    rxPushN(7);
    @(negedge clk);
    chk("R11 warning irq", {31'd0, irq}, 32'd1);
    swWrite(32'hFFFF_FFF7);
    @(negedge clk);
    chk("R11 irq drops", {31'd0, irq}, 32'd0);
    rxPushN(1);
    @(negedge clk);
    chk("R11 error irq", {31'd0, irq}, 32'd1);
    swWrite(32'hFFFF_FFEF);

    ctrlEn = 7'b000_0010; txDoneIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 transmit done irq", {31'd0, irq}, 32'd1);
    ctrlEn = 7'b000_0000;
    repeat (2) @(negedge clk);
    chk("R10 all disabled", {31'd0, irq}, 32'd0);
    txDoneIn = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule